// File: doc/BRIEF.md
# Accumulator ALU with condition-code update

This block is the combinational arithmetic and logic unit of a small two-accumulator processor. The datapath delivers an accumulator operand and a second operand, taken from memory or from the other accumulator. It also delivers an operation code and the current condition-code bits. In the same cycle the unit returns an 8-bit result, a new set of condition codes and a write-enable. The write-enable tells the register file whether the result goes back into the accumulator.

Every operation class has its own rule for each flag. A flag may be computed from the result, forced to 0 or 1, or passed through unchanged. Shifts and rotates derive overflow from the sign and the carry after the shift. Decimal adjust corrects a packed-BCD sum using the half-carry and carry left behind by a previous add. Operand fetch, addressing and register storage stay with the surrounding datapath.

Condition-code vector `cc_in`/`cc_out` bit order: 5 half-carry, 4 interrupt mask, 3 negative, 2 zero, 1 overflow, 0 carry. Unary operations act on `opd_a`; `opd_b` is used only by the two-operand operations.

Top module: `acc_alu`

## Requirements
- R1: Op codes 0 (add) and 1 (add with carry-in from bit 0 of `cc_in`) give a+b(+C) modulo 256, write it back, and update all five flags: half-carry is the carry out of bit 3, carry is the carry out of bit 7, and overflow is the two's-complement overflow.
- R2: Op codes 2 (subtract) and 3 (subtract with borrow, C as borrow) give a−b(−C), write it back, set C on a borrow, set V on signed overflow, update N and Z, and keep H.
- R3: Op code 4 (compare, a−b with the flags of R2) and op code 8 (bit test, a AND b with the flags of R4) produce their result and flags with write-enable low.
- R4: Op codes 5 (AND), 6 (OR), 7 (XOR) and 9 (load, result = b) write back, update N and Z, clear V and keep C.
- R5: Op code 10 (clear) writes 0x00 with N=0, Z=1, V=0 and C=0.
- R6: Op code 11 (one's complement of a) updates N and Z, clears V and sets C. Op code 12 (0x00 − a) sets V only for a=0x80 and sets C exactly when the result is nonzero.
- R7: Op code 13 (a+1) sets V only for a=0x7F. Op code 14 (a−1) sets V only for a=0x80. Both update N and Z and keep C.
- R8: Op code 15 (test) returns a with write-enable low, updates N and Z, and clears V and C.
- R9: Op codes 16 (shift left, 0 in), 17 (arithmetic right, bit 7 kept), 19 (rotate left through C) and 20 (rotate right through C) move the bit shifted out into C. They update N and Z and set V to N XOR C after the operation.
- R10: Op code 18 (logical shift right) clears bit 7 of the result, so N is always 0. C takes bit 0 of a and V equals C.
- R11: Op code 21 (decimal adjust) adds 0x06 when H is set or the low nibble exceeds 9. It adds 0x60 when C is set, when the high nibble exceeds 9, or when the high nibble is at least 9 and the low nibble exceeds 9. C becomes the old C OR the high correction, N and Z follow the result, and V and H are kept.
- R12: The interrupt-mask bit always passes through unchanged. Half-carry is changed only by op codes 0 and 1.
- R13: Op codes 22 to 31 are unused: result 0x00, write-enable low, and `cc_out` equal to `cc_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code |
| opd_a | input | 8 | Accumulator operand |
| opd_b | input | 8 | Second operand |
| cc_in | input | 6 | Incoming condition codes (H,I,N,Z,V,C) |
| result | output | 8 | Operation result |
| cc_out | output | 6 | Updated condition codes |
| wr_en | output | 1 | High when the result is to be written back |

## Verification
Every result, flag and write-enable is purely combinational, so each one is due in the same cycle its operands and operation code are applied, with no register in between. The driver applies one stimulus just after a rising edge and queues the expected values. The monitor pops and compares them at the following falling edge, half a period later. By then the inputs have been stable for several nanoseconds, and the next stimulus is not applied until the next rising edge.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W = 5;
  localparam int CC_W = 6;

  localparam int CC_H = 5;
  localparam int CC_I = 4;
  localparam int CC_N = 3;
  localparam int CC_Z = 2;
  localparam int CC_V = 1;
  localparam int CC_C = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,
    OP_ADC = 5'd1,
    OP_SUB = 5'd2,
    OP_SBC = 5'd3,
    OP_CMP = 5'd4,
    OP_AND = 5'd5,
    OP_OR  = 5'd6,
    OP_XOR = 5'd7,
    OP_BIT = 5'd8,
    OP_LD  = 5'd9,
    OP_CLR = 5'd10,
    OP_COM = 5'd11,
    OP_NEG = 5'd12,
    OP_INC = 5'd13,
    OP_DEC = 5'd14,
    OP_TST = 5'd15,
    OP_ASL = 5'd16,
    OP_ASR = 5'd17,
    OP_LSR = 5'd18,
    OP_ROL = 5'd19,
    OP_ROR = 5'd20,
    OP_DAA = 5'd21
  } alu_op_e;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] add_x,
  input  logic [DATA_W-1:0] add_y,
  input  logic              add_ci,
  output logic [DATA_W-1:0] add_sum,
  output logic              add_co,
  output logic              add_hc,
  output logic              add_ov
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W:0] carry;

  assign carry[0] = add_ci;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      assign add_sum[gi]  = add_x[gi] ^ add_y[gi] ^ carry[gi];
      assign carry[gi+1]  = (add_x[gi] & add_y[gi]) |
                            (add_x[gi] & carry[gi]) |
                            (add_y[gi] & carry[gi]);
    end
  endgenerate

  assign add_co = carry[DATA_W];
  assign add_hc = carry[HALF_W];
  assign add_ov = carry[DATA_W] ^ carry[DATA_W-1];

  // Ripple chain against a plain wide add.
  always_comb begin
    assert_adder_sum_R1: assert ({add_co, add_sum} ==
      ({1'b0, add_x} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_ci}));
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           lg_op,
  input  logic [DATA_W-1:0] lg_a,
  input  logic [DATA_W-1:0] lg_b,
  output logic [DATA_W-1:0] lg_res
);

  always_comb begin
    unique case (lg_op)
      OP_AND, OP_BIT: lg_res = lg_a & lg_b;
      OP_OR:          lg_res = lg_a | lg_b;
      OP_XOR:         lg_res = lg_a ^ lg_b;
      OP_LD:          lg_res = lg_b;
      OP_COM:         lg_res = ~lg_a;
      default:        lg_res = '0;
    endcase
  end

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           sh_op,
  input  logic [DATA_W-1:0] sh_a,
  input  logic              sh_cin,
  output logic [DATA_W-1:0] sh_res,
  output logic              sh_cout
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] left_v;
  logic [DATA_W-1:0] right_v;
  logic              fill_l;
  logic              fill_r;
  logic              go_left;

  always_comb begin
    go_left = (sh_op == OP_ASL) || (sh_op == OP_ROL);
    fill_l  = (sh_op == OP_ROL) ? sh_cin : 1'b0;
    unique case (sh_op)
      OP_ASR:  fill_r = sh_a[MSB];
      OP_ROR:  fill_r = sh_cin;
      default: fill_r = 1'b0;
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_lane
      if (gi == 0) begin : g_lo
        assign left_v[gi] = fill_l;
      end else begin : g_lo_n
        assign left_v[gi] = sh_a[gi-1];
      end
      if (gi == MSB) begin : g_hi
        assign right_v[gi] = fill_r;
      end else begin : g_hi_n
        assign right_v[gi] = sh_a[gi+1];
      end
    end
  endgenerate

  assign sh_res  = go_left ? left_v : right_v;
  assign sh_cout = go_left ? sh_a[MSB] : sh_a[0];

endmodule

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] bcd_a,
  input  logic              bcd_hin,
  input  logic              bcd_cin,
  output logic [DATA_W-1:0] bcd_res,
  output logic              bcd_cout
);
  localparam int NIB_W = DATA_W / 2;
  localparam logic [NIB_W-1:0] NIB_NINE = NIB_W'(9);
  localparam logic [NIB_W-1:0] NIB_SIX  = NIB_W'(6);

  logic [NIB_W-1:0]  lo_nib;
  logic [NIB_W-1:0]  hi_nib;
  logic              fix_lo;
  logic              fix_hi;
  logic [DATA_W-1:0] adj;

  always_comb begin
    lo_nib  = bcd_a[NIB_W-1:0];
    hi_nib  = bcd_a[DATA_W-1:NIB_W];
    fix_lo  = bcd_hin || (lo_nib > NIB_NINE);
    fix_hi  = bcd_cin || (hi_nib > NIB_NINE) ||
              ((hi_nib >= NIB_NINE) && (lo_nib > NIB_NINE));
    adj     = {(fix_hi ? NIB_SIX : '0), (fix_lo ? NIB_SIX : '0)};
    bcd_res  = bcd_a + adj;
    bcd_cout = bcd_cin | fix_hi;
  end

  // A carry already present is never lost by the adjust.
  always_comb begin
    if (bcd_cin) begin
      assert_bcd_carry_R11: assert (bcd_cout);
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [4:0]        op_sel,
  input  logic [DATA_W-1:0] opd_a,
  input  logic [DATA_W-1:0] opd_b,
  input  logic [5:0]        cc_in,
  output logic [DATA_W-1:0] result,
  output logic [5:0]        cc_out,
  output logic              wr_en
);
  localparam int MSB = DATA_W - 1;

  alu_op_e           op;
  logic [DATA_W-1:0] ad_x;
  logic [DATA_W-1:0] ad_y;
  logic              ad_ci;
  logic [DATA_W-1:0] ad_sum;
  logic              ad_co;
  logic              ad_hc;
  logic              ad_ov;
  logic [DATA_W-1:0] lg_res;
  logic [DATA_W-1:0] sh_res;
  logic              sh_c;
  logic [DATA_W-1:0] bcd_res;
  logic              bcd_c;
  logic              nz_upd;

  assign op = alu_op_e'(op_sel);

  // Operand steering for the shared adder.
  always_comb begin
    ad_x  = opd_a;
    ad_y  = opd_b;
    ad_ci = 1'b0;
    unique case (op)
      OP_ADC:         ad_ci = cc_in[CC_C];
      OP_SUB, OP_CMP: begin ad_y = ~opd_b; ad_ci = 1'b1; end
      OP_SBC:         begin ad_y = ~opd_b; ad_ci = ~cc_in[CC_C]; end
      OP_NEG:         begin ad_x = '0; ad_y = ~opd_a; ad_ci = 1'b1; end
      OP_INC:         begin ad_y = '0; ad_ci = 1'b1; end
      OP_DEC:         begin ad_y = '1; ad_ci = 1'b0; end
      OP_TST:         begin ad_y = '1; ad_ci = 1'b1; end
      default:        ;
    endcase
  end

  acc_alu_adder #(.DATA_W(DATA_W)) u_adder (
    .add_x  (ad_x),
    .add_y  (ad_y),
    .add_ci (ad_ci),
    .add_sum(ad_sum),
    .add_co (ad_co),
    .add_hc (ad_hc),
    .add_ov (ad_ov)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .lg_op (op),
    .lg_a  (opd_a),
    .lg_b  (opd_b),
    .lg_res(lg_res)
  );

  acc_alu_shift #(.DATA_W(DATA_W)) u_shift (
    .sh_op  (op),
    .sh_a   (opd_a),
    .sh_cin (cc_in[CC_C]),
    .sh_res (sh_res),
    .sh_cout(sh_c)
  );

  acc_alu_bcd #(.DATA_W(DATA_W)) u_bcd (
    .bcd_a   (opd_a),
    .bcd_hin (cc_in[CC_H]),
    .bcd_cin (cc_in[CC_C]),
    .bcd_res (bcd_res),
    .bcd_cout(bcd_c)
  );

  // Per-class result and flag rules.
  always_comb begin
    result = '0;
    cc_out = cc_in;
    wr_en  = 1'b0;
    nz_upd = 1'b1;
    unique case (op)
      OP_ADD, OP_ADC: begin
        result       = ad_sum;
        wr_en        = 1'b1;
        cc_out[CC_H] = ad_hc;
        cc_out[CC_V] = ad_ov;
        cc_out[CC_C] = ad_co;
      end
      OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
        result       = ad_sum;
        wr_en        = (op != OP_CMP);
        cc_out[CC_V] = ad_ov;
        cc_out[CC_C] = ~ad_co;
      end
      OP_INC, OP_DEC: begin
        result       = ad_sum;
        wr_en        = 1'b1;
        cc_out[CC_V] = ad_ov;
      end
      OP_TST: begin
        result       = ad_sum;
        cc_out[CC_V] = 1'b0;
        cc_out[CC_C] = 1'b0;
      end
      OP_AND, OP_OR, OP_XOR, OP_BIT, OP_LD: begin
        result       = lg_res;
        wr_en        = (op != OP_BIT);
        cc_out[CC_V] = 1'b0;
      end
      OP_CLR: begin
        result       = '0;
        wr_en        = 1'b1;
        cc_out[CC_V] = 1'b0;
        cc_out[CC_C] = 1'b0;
      end
      OP_COM: begin
        result       = lg_res;
        wr_en        = 1'b1;
        cc_out[CC_V] = 1'b0;
        cc_out[CC_C] = 1'b1;
      end
      OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
        result       = sh_res;
        wr_en        = 1'b1;
        cc_out[CC_C] = sh_c;
        cc_out[CC_V] = sh_res[MSB] ^ sh_c;
      end
      OP_DAA: begin
        result       = bcd_res;
        wr_en        = 1'b1;
        cc_out[CC_C] = bcd_c;
      end
      default: nz_upd = 1'b0;
    endcase
    if (nz_upd) begin
      cc_out[CC_N] = result[MSB];
      cc_out[CC_Z] = (result == '0);
    end
  end

  always_comb begin
    if ((op == OP_CMP) || (op == OP_BIT) || (op == OP_TST)) begin
      assert_no_store_R3: assert (!wr_en);
    end
    if ((op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_LD)) begin
      assert_logic_c_kept_R4: assert ((cc_out[CC_C] == cc_in[CC_C]) && !cc_out[CC_V]);
    end
    if (op == OP_CLR) begin
      assert_clear_zero_R5: assert ((lg_res == '0) && (result == '0) && cc_out[CC_Z]);
    end
    if ((op == OP_ASL) || (op == OP_ASR) || (op == OP_ROL) || (op == OP_ROR)) begin
      assert_shift_v_R9: assert (cc_out[CC_V] == (cc_out[CC_N] ^ cc_out[CC_C]));
    end
    if (op == OP_LSR) begin
      assert_lsr_positive_R10: assert (!cc_out[CC_N] && (cc_out[CC_V] == opd_a[0]));
    end
    if (op_sel > 5'd21) begin
      assert_unused_quiet_R13: assert (!wr_en && (cc_out == cc_in));
    end
    assert_mask_kept_R12: assert (cc_out[CC_I] == cc_in[CC_I]);
  end

endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;

  typedef struct packed {
    logic [7:0] res;
    logic [5:0] cc;
    logic       wr;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic [4:0] op_sel;
  logic [7:0] opd_a;
  logic [7:0] opd_b;
  logic [5:0] cc_in;
  logic [7:0] result;
  logic [5:0] cc_out;
  logic       wr_en;

  int total;
  int bad;
  bit finished;

  exp_t  q_exp[$];
  string q_tag[$];
  logic [5:0] q_cin[$];
  logic [4:0] q_op[$];

  acc_alu i_acc_alu (
    .op_sel(op_sel),
    .opd_a (opd_a),
    .opd_b (opd_b),
    .cc_in (cc_in),
    .result(result),
    .cc_out(cc_out),
    .wr_en (wr_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'd0, 5'd1:                 return "R1";
      5'd2, 5'd3:                 return "R2";
      5'd4, 5'd8:                 return "R3";
      5'd5, 5'd6, 5'd7, 5'd9:     return "R4";
      5'd10:                      return "R5";
      5'd11, 5'd12:               return "R6";
      5'd13, 5'd14:               return "R7";
      5'd15:                      return "R8";
      5'd16, 5'd17, 5'd19, 5'd20: return "R9";
      5'd18:                      return "R10";
      5'd21:                      return "R11";
      default:                    return "R13";
    endcase
  endfunction

  // Reference model written from the requirements with integer arithmetic.
  function automatic exp_t model(input logic [4:0] op, input logic [7:0] a,
                                 input logic [7:0] b, input logic [5:0] ci);
    exp_t e;
    int   s;
    logic [7:0] r;
    logic h, n, z, v, c, wr, nz, shf;
    logic cin;
    h = ci[5]; n = ci[3]; z = ci[2]; v = ci[1]; c = ci[0];
    cin = ci[0];
    r = 8'h00; wr = 1'b1; nz = 1'b1; shf = 1'b0;
    case (op)
      5'd0, 5'd1: begin
        s = int'(a) + int'(b) + ((op == 5'd1) ? int'(cin) : 0);
        r = s[7:0];
        c = (s > 255);
        h = ((int'(a[3:0]) + int'(b[3:0]) + ((op == 5'd1) ? int'(cin) : 0)) > 15);
        v = (a[7] == b[7]) && (r[7] != a[7]);
      end
      5'd2, 5'd3, 5'd4: begin
        s = int'(a) - int'(b) - ((op == 5'd3) ? int'(cin) : 0);
        r = s[7:0];
        c = (s < 0);
        v = (a[7] != b[7]) && (r[7] != a[7]);
        wr = (op != 5'd4);
      end
      5'd5:  begin r = a & b; v = 1'b0; end
      5'd6:  begin r = a | b; v = 1'b0; end
      5'd7:  begin r = a ^ b; v = 1'b0; end
      5'd8:  begin r = a & b; v = 1'b0; wr = 1'b0; end
      5'd9:  begin r = b; v = 1'b0; end
      5'd10: begin r = 8'h00; v = 1'b0; c = 1'b0; end
      5'd11: begin r = ~a; v = 1'b0; c = 1'b1; end
      5'd12: begin r = 8'h00 - a; v = (a == 8'h80); c = (r != 8'h00); end
      5'd13: begin r = a + 8'h01; v = (a == 8'h7F); end
      5'd14: begin r = a - 8'h01; v = (a == 8'h80); end
      5'd15: begin r = a; v = 1'b0; c = 1'b0; wr = 1'b0; end
      5'd16: begin r = {a[6:0], 1'b0}; c = a[7]; shf = 1'b1; end
      5'd17: begin r = {a[7], a[7:1]}; c = a[0]; shf = 1'b1; end
      5'd18: begin r = {1'b0, a[7:1]}; c = a[0]; shf = 1'b1; end
      5'd19: begin r = {a[6:0], cin}; c = a[7]; shf = 1'b1; end
      5'd20: begin r = {cin, a[7:1]}; c = a[0]; shf = 1'b1; end
      5'd21: begin
        logic lo9, hi9, fl, fh;
        lo9 = (a[3:0] > 4'd9);
        hi9 = (a[7:4] > 4'd9);
        fl = ci[5] || lo9;
        fh = cin || hi9 || ((a[7:4] >= 4'd9) && lo9);
        r = a + (fl ? 8'h06 : 8'h00) + (fh ? 8'h60 : 8'h00);
        c = cin | fh;
      end
      default: begin r = 8'h00; wr = 1'b0; nz = 1'b0; end
    endcase
    if (nz) begin
      n = r[7];
      z = (r == 8'h00);
    end
    if (shf) v = n ^ c;
    e.res = r;
    e.cc  = {h, ci[4], n, z, v, c};
    e.wr  = wr;
    return e;
  endfunction

  task automatic drive(input logic [4:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [5:0] ci);
    @(posedge clk);
    #1;
    op_sel = op; opd_a = a; opd_b = b; cc_in = ci;
    q_exp.push_back(model(op, a, b, ci));
    q_tag.push_back(tag_of(op));
    q_cin.push_back(ci);
    q_op.push_back(op);
  endtask

  // Monitor: results are combinational, due half a period after the drive.
  always @(negedge clk) begin
    if (rst_n && !finished && (q_exp.size() > 0)) begin
      exp_t  e;
      string t;
      logic [5:0] ci;
      logic [4:0] op;
      e  = q_exp.pop_front();
      t  = q_tag.pop_front();
      ci = q_cin.pop_front();
      op = q_op.pop_front();
      total++;
      if ((result !== e.res) || (cc_out !== e.cc) || (wr_en !== e.wr)) begin
        bad++;
        $display("FAIL %s op=%0d a=%h b=%h cc=%b: got res=%h cc=%b wr=%b expected res=%h cc=%b wr=%b",
                 t, op, opd_a, opd_b, ci, result, cc_out, wr_en, e.res, e.cc, e.wr);
      end
      // R12: mask bit always passes, half-carry only moved by adds.
      if (op > 5'd1) begin
        total++;
        if ((cc_out[4] !== ci[4]) || (cc_out[5] !== ci[5])) begin
          bad++;
          $display("FAIL R12 op=%0d: got H,I=%b%b expected %b%b",
                   op, cc_out[5], cc_out[4], ci[5], ci[4]);
        end
      end
    end
  end

  logic [7:0] pat_a [10] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h5A, 8'h9A, 8'h15, 8'h0F, 8'hC3};
  logic [7:0] pat_b [10] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h01, 8'hA5, 8'h66, 8'h27, 8'hF1, 8'h3C};
  logic [5:0] pat_c [10] = '{6'b000000, 6'b000001, 6'b100000, 6'b010101, 6'b111111,
                             6'b101010, 6'b000100, 6'b100001, 6'b011000, 6'b110011};

  initial begin
    total = 0; bad = 0; finished = 1'b0;
    rst_n = 1'b0;
    op_sel = 5'd0; opd_a = 8'h00; opd_b = 8'h00; cc_in = 6'b000000;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Idle state after reset: add of zeros gives zero with Z set (R1).
    drive(5'd0, 8'h00, 8'h00, 6'b000000);
    // R1 corners: signed overflow with half-carry, and full carry out.
    drive(5'd0, 8'h7F, 8'h01, 6'b000000);
    drive(5'd0, 8'hFF, 8'h01, 6'b000000);
    drive(5'd1, 8'h0F, 8'h00, 6'b000001);
    // R2 corners: borrow, signed overflow, borrow-in.
    drive(5'd2, 8'h00, 8'h01, 6'b100000);
    drive(5'd2, 8'h80, 8'h01, 6'b000000);
    drive(5'd3, 8'h10, 8'h10, 6'b000001);
    // R3 compare equal, bit test
    drive(5'd4, 8'h42, 8'h42, 6'b000000);
    drive(5'd8, 8'hF0, 8'h0F, 6'b000001);
    // R6 negate corners
    drive(5'd12, 8'h80, 8'h00, 6'b000000);
    drive(5'd12, 8'h00, 8'h00, 6'b000001);
    // R7 increment / decrement overflow corners
    drive(5'd13, 8'h7F, 8'h00, 6'b000001);
    drive(5'd14, 8'h80, 8'h00, 6'b000000);
    // R10 logical shift right, R9 rotate with carry in
    drive(5'd18, 8'h81, 8'h00, 6'b000000);
    drive(5'd19, 8'h80, 8'h00, 6'b000001);
    drive(5'd20, 8'h01, 8'h00, 6'b000000);
    // R11 decimal adjust corners
    drive(5'd21, 8'h9A, 8'h00, 6'b000000);
    drive(5'd21, 8'h15, 8'h00, 6'b100000);
    drive(5'd21, 8'h42, 8'h00, 6'b000001);
    drive(5'd21, 8'h99, 8'h00, 6'b000000);

    // Sweep all op codes over mixed operand and flag patterns.
    for (int op = 0; op < 32; op++) begin
      for (int k = 0; k < 10; k++) begin
        drive(5'(op), pat_a[k], pat_b[k], pat_c[k]);
      end
    end

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule